// File: doc/BRIEF.md
# Eight-Bit Port Pin Multiplexer

This block controls one eight-pin general-purpose port and lets a set of fixed on-chip peripherals take over selected pins. When a peripheral's enable is low, its pins behave as plain I/O. Plain I/O is driven from a data register and a direction register. An input register returns the pin levels. All three registers sit on a small synchronous register bus. When a peripheral is enabled, it claims its own pins. It then overrides the register settings on those pins, whatever they contain.

Four functions claim pins:
- A two-wire serial interface takes pins 7 and 6. It drives them open-drain.
- The receive side of a UART takes pin 5.
- The transmit side of the UART takes pin 4.
- Two converter output channels take pins 1 and 0.

Pin 2 is not implemented. For every pin, the block drives a pad output value, an output enable and a pull-up enable. Every pad input passes through a two-flop synchronizer before any read path or peripheral uses it.

Top module: `port_pin_mux`

## Requirements
- R1: While reset is low, and on the first cycle after it, the data and direction registers are zero and every pad output enable is 0. `pad_pu` is 8'hF0, and `pad_out` is 0 when no peripheral is enabled.
- R2: The register address selects one register: 0 is the data register, 1 is the input register, 2 is the direction register, and 3 reads as 0.
  - A write is one cycle with `bus_wr` high, and the write takes effect at the next rising edge.
  - `bus_rdata` follows `bus_addr` combinationally.
  - A write to address 1 or 3 changes nothing.
- R3: On a pin that no enabled peripheral claims, `pad_out` equals the data register bit and `pad_oe` equals the direction register bit.
- R4: Reading address 0 returns, for each bit, the data register bit if the direction bit is 1, and the synchronized pin level if the direction bit is 0.
- R5: Reading address 1 returns the synchronized pin levels in every direction setting. A change on `pad_in` appears there after the second rising edge, not after the first.
- R6: Bit 2 reads as 0 at every address, and writes to bit 2 are dropped. Pin 2 is never driven and never pulled up: `pad_oe[2]`, `pad_out[2]` and `pad_pu[2]` are all 0.
- R7: With `i2c_en` high, pins 7 (clock) and 6 (data) behave as open-drain pins:
  - `pad_out` is 0 on both pins.
  - `pad_oe[7]` equals `i2c_scl_drive_low` and `pad_oe[6]` equals `i2c_sda_drive_low`.
  - `i2c_scl_in` and `i2c_sda_in` carry the synchronized levels of pins 7 and 6, and read 1 while `i2c_en` is low.
- R8: With `uart_rx_en` high, pin 5 is an undriven input, and `uart_rxd` carries its synchronized level. `uart_rxd` is 1 while `uart_rx_en` is low. With `uart_tx_en` high, pin 4 drives `uart_txd` with its output enable set to 1.
- R9: With `dac0_en` high, pin 0 drives `dac0_out` with its output enable set to 1. `dac1_en` does the same for pin 1 with `dac1_out`.
- R10: `pad_pu` is 1 exactly on pins 7 to 4 whose `pad_oe` is 0. Pins 3 to 0 never have a pull-up.
- R11: An enabled peripheral wins on its pins whatever the direction and data registers hold. When its enable falls, the pin returns to the register-driven values in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 input, 2 direction |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| i2c_en | input | 1 | Two-wire interface claims pins 7 and 6 |
| i2c_scl_drive_low | input | 1 | Pull the clock line low |
| i2c_sda_drive_low | input | 1 | Pull the data line low |
| i2c_scl_in | output | 1 | Synchronized clock line level |
| i2c_sda_in | output | 1 | Synchronized data line level |
| uart_rx_en | input | 1 | UART receiver claims pin 5 |
| uart_tx_en | input | 1 | UART transmitter claims pin 4 |
| uart_txd | input | 1 | Transmit bit for pin 4 |
| uart_rxd | output | 1 | Synchronized receive level from pin 5 |
| dac0_en | input | 1 | Converter channel 0 claims pin 0 |
| dac0_out | input | 1 | Channel 0 drive value |
| dac1_en | input | 1 | Converter channel 1 claims pin 1 |
| dac1_out | input | 1 | Channel 1 drive value |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The state is small, and each kind of fault shows at the ports within one or two cycles:
- A wrong data or direction register bit shows on `pad_out` or `pad_oe` in the cycle after the write that set it, unless a peripheral currently claims that pin. It also shows on an address-0 or address-2 read in that same cycle.
- A synchronizer with the wrong depth shows on address-1 reads. The read changes one cycle early or late after a pad transition.
- An override on the wrong pin, or with the wrong polarity, shows combinationally in the cycle its enable rises. The bench therefore compares every output against a behavioural model on every clock, across directed override cases and a random phase.

// File: rtl/ppm_pkg.sv
// Package: shared register selects, fixed pin positions and the per-pin
// override record used by the port pin multiplexer.
package ppm_pkg;

    // Register select codes on the register bus.
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_IN   = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Fixed pin ownership of each peripheral function.
    localparam int PIN_SCL = 7;
    localparam int PIN_SDA = 6;
    localparam int PIN_RXD = 5;
    localparam int PIN_TXD = 4;
    localparam int PIN_CV1 = 1;
    localparam int PIN_CV0 = 0;

    // Per-pin peripheral request: claim flag, drive value, output enable.
    typedef struct packed {
        logic own;
        logic out;
        logic oe;
    } pin_ctl_t;

endpackage

// File: rtl/ppm_sync.sv
// Module: ppm_sync
// Two-flop synchronizer, one pair of flops per pin.
// Assumes: the flops carry no reset, so pin readings are not disturbed by
// reset. Their output is only meaningful two edges after the clock starts.
module ppm_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Capture the raw level, then re-time it once more.
        always_ff @(posedge clk) begin
            stage1_q[g] <= async_in[g];
            stage2_q[g] <= stage1_q[g];
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/ppm_regs.sv
// Module: ppm_regs
// Data and direction registers plus the combinational read multiplexer.
// Assumes: bus_wr is a one-cycle strobe. Bits cleared in IMPL_MASK do not
// exist: they are never stored and they read as 0.
module ppm_regs
    import ppm_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hFB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    // Data register: cleared by reset, loaded on a write to its select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (bus_wr && sel == SEL_DATA) begin
            data_q <= bus_wdata & IMPL_MASK;
        end
    end

    // Direction register: cleared by reset (all inputs), loaded on its select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (bus_wr && sel == SEL_DIR) begin
            dir_q <= bus_wdata & IMPL_MASK;
        end
    end

    // Read multiplexer: the data read depends on each bit's direction.
    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = ((dir_q & data_q) | (~dir_q & pin_sync)) & IMPL_MASK;
            SEL_IN:   bus_rdata = pin_sync & IMPL_MASK;
            SEL_DIR:  bus_rdata = dir_q & IMPL_MASK;
            default:  bus_rdata = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (data_q == '0 && dir_q == '0));                          // R1
    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == 2'd1)
            |-> ($stable(data_q) && $stable(dir_q)));                               // R2
    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == '0);                                            // R6

endmodule

// File: rtl/ppm_route.sv
// Module: ppm_route
// Per-pin selection between the peripheral request and the GPIO registers,
// and the pull-up control for each pad.
// Assumes: at most one peripheral requests each pin. The top fixes the
// ownership, so no arbitration happens here.
module ppm_route
    import ppm_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hFB,
    parameter logic [WIDTH-1:0] PULL_MASK = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     data_q,
    input  logic [WIDTH-1:0]     dir_q,
    input  pin_ctl_t [WIDTH-1:0] req,
    output logic [WIDTH-1:0]     pad_out,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_pu
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        if (IMPL_MASK[g]) begin : g_live
            // A claiming peripheral wins over the GPIO registers.
            always_comb begin
                if (req[g].own) begin
                    pad_out[g] = req[g].out;
                    pad_oe[g]  = req[g].oe;
                end else begin
                    pad_out[g] = data_q[g];
                    pad_oe[g]  = dir_q[g];
                end
            end
            // Pull-up applies only on pull-capable pins that are not driven.
            assign pad_pu[g] = PULL_MASK[g] & ~pad_oe[g];
        end else begin : g_absent
            assign pad_out[g] = 1'b0;
            assign pad_oe[g]  = 1'b0;
            assign pad_pu[g]  = 1'b0;
        end
    end

    AST_PULL_ONLY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);                                                   // R10
    AST_PULL_PINS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~PULL_MASK) == '0);                                               // R10

endmodule

// File: rtl/port_pin_mux.sv
// Module: port_pin_mux (top)
// Eight-pin port controller. Fixed peripheral functions override GPIO on
// the pins they own. The I2C pins run open-drain.
// Assumes: the default parameters describe the eight-pin port. The
// peripheral pin positions come from ppm_pkg.
module port_pin_mux
    import ppm_pkg::*;
#(
    parameter int                   NUM_PINS  = 8,
    parameter logic [NUM_PINS-1:0]  IMPL_MASK = 8'hFB,
    parameter logic [NUM_PINS-1:0]  PULL_MASK = 8'hF0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic                i2c_en,
    input  logic                i2c_scl_drive_low,
    input  logic                i2c_sda_drive_low,
    output logic                i2c_scl_in,
    output logic                i2c_sda_in,
    input  logic                uart_rx_en,
    input  logic                uart_tx_en,
    input  logic                uart_txd,
    output logic                uart_rxd,
    input  logic                dac0_en,
    input  logic                dac0_out,
    input  logic                dac1_en,
    input  logic                dac1_out,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    pin_ctl_t [NUM_PINS-1:0] req;

    ppm_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk      (clk),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    ppm_regs #(.WIDTH(NUM_PINS), .IMPL_MASK(IMPL_MASK)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    // Build the per-pin peripheral requests from the fixed pin assignment.
    always_comb begin
        req = '0;
        req[PIN_SCL] = '{own: i2c_en,     out: 1'b0,     oe: i2c_scl_drive_low};
        req[PIN_SDA] = '{own: i2c_en,     out: 1'b0,     oe: i2c_sda_drive_low};
        req[PIN_RXD] = '{own: uart_rx_en, out: 1'b0,     oe: 1'b0};
        req[PIN_TXD] = '{own: uart_tx_en, out: uart_txd, oe: 1'b1};
        req[PIN_CV1] = '{own: dac1_en,    out: dac1_out, oe: 1'b1};
        req[PIN_CV0] = '{own: dac0_en,    out: dac0_out, oe: 1'b1};
    end

    ppm_route #(.WIDTH(NUM_PINS), .IMPL_MASK(IMPL_MASK), .PULL_MASK(PULL_MASK)) i_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .req     (req),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // Return synchronized line levels to the peripherals, idle-high when off.
    assign i2c_scl_in = i2c_en     ? pin_sync[PIN_SCL] : 1'b1;
    assign i2c_sda_in = i2c_en     ? pin_sync[PIN_SDA] : 1'b1;
    assign uart_rxd   = uart_rx_en ? pin_sync[PIN_RXD] : 1'b1;

    AST_I2C_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_en |-> (pad_out[PIN_SCL] == 1'b0 && pad_out[PIN_SDA] == 1'b0
                    && pad_oe[PIN_SCL] == i2c_scl_drive_low
                    && pad_oe[PIN_SDA] == i2c_sda_drive_low));                      // R7
    AST_RX_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        uart_rx_en |-> !pad_oe[PIN_RXD]);                                           // R8
    AST_TX_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        uart_tx_en |-> (pad_oe[PIN_TXD] && pad_out[PIN_TXD] == uart_txd));          // R8
    AST_CONV_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (dac0_en |-> (pad_oe[PIN_CV0] && pad_out[PIN_CV0] == dac0_out))
        and (dac1_en |-> (pad_oe[PIN_CV1] && pad_out[PIN_CV1] == dac1_out)));       // R9
    AST_PIN2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[2] == 1'b0 && pad_out[2] == 1'b0 && pad_pu[2] == 1'b0));            // R6
    AST_GPIO_PIN3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[3] == dir_q[3] && pad_out[3] == data_q[3]));                        // R3

endmodule

// File: tb/test_port_pin_mux.sv
// Bench: behavioural reference model compared against every output on each
// clock, plus directed checks on reset, register access and overrides.
module test_port_pin_mux;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic i2c_en, i2c_scl_drive_low, i2c_sda_drive_low, i2c_scl_in, i2c_sda_in;
    logic uart_rx_en, uart_tx_en, uart_txd, uart_rxd;
    logic dac0_en, dac0_out, dac1_en, dac1_out;
    logic [7:0] pad_in, pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    port_pin_mux i_port_pin_mux (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .i2c_en(i2c_en), .i2c_scl_drive_low(i2c_scl_drive_low),
        .i2c_sda_drive_low(i2c_sda_drive_low), .i2c_scl_in(i2c_scl_in),
        .i2c_sda_in(i2c_sda_in), .uart_rx_en(uart_rx_en), .uart_tx_en(uart_tx_en),
        .uart_txd(uart_txd), .uart_rxd(uart_rxd), .dac0_en(dac0_en),
        .dac0_out(dac0_out), .dac1_en(dac1_en), .dac1_out(dac1_out),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
        end
    endtask

    // Reference model state: registers and a queue of pad samples.
    logic [7:0] m_data, m_dir;
    logic [7:0] pad_hist[$];

    always @(posedge clk) begin
        cyc++;
        pad_hist.push_back(pad_in);
        if (pad_hist.size() > 2) void'(pad_hist.pop_front());
        if (!rst_n) begin
            m_data = 8'h00;
            m_dir  = 8'h00;
        end else if (bus_wr) begin
            if (bus_addr == 2'd0) m_data = bus_wdata & 8'hFB;
            if (bus_addr == 2'd2) m_dir  = bus_wdata & 8'hFB;
        end
    end

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (cyc >= 3) begin
            logic [7:0] s, eo, ev, epu, erd;
            s  = pad_hist[0];
            eo = m_dir;
            ev = m_data;
            if (dac0_en)    begin ev[0] = dac0_out; eo[0] = 1'b1; end
            if (dac1_en)    begin ev[1] = dac1_out; eo[1] = 1'b1; end
            if (uart_tx_en) begin ev[4] = uart_txd; eo[4] = 1'b1; end
            if (uart_rx_en) begin ev[5] = 1'b0;     eo[5] = 1'b0; end
            if (i2c_en) begin
                ev[7] = 1'b0; eo[7] = i2c_scl_drive_low;
                ev[6] = 1'b0; eo[6] = i2c_sda_drive_low;
            end
            epu = 8'hF0 & ~eo;
            case (bus_addr)
                2'd0:    erd = ((m_dir & m_data) | (~m_dir & s)) & 8'hFB;
                2'd1:    erd = s & 8'hFB;
                2'd2:    erd = m_dir;
                default: erd = 8'h00;
            endcase
            chk("R3 R7 R8 R9 R11 pad_out", pad_out, ev);
            chk("R3 R7 R8 R9 R11 pad_oe", pad_oe, eo);
            chk("R10 pad_pu", pad_pu, epu);
            chk("R2 R4 R5 R6 bus_rdata", bus_rdata, erd);
            chk("R7 R8 peripheral inputs", {5'd0, i2c_scl_in, i2c_sda_in, uart_rxd},
                {5'd0, i2c_en ? s[7] : 1'b1, i2c_en ? s[6] : 1'b1, uart_rx_en ? s[5] : 1'b1});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
        i2c_en = 0; i2c_scl_drive_low = 0; i2c_sda_drive_low = 0;
        uart_rx_en = 0; uart_tx_en = 0; uart_txd = 0;
        dac0_en = 0; dac0_out = 0; dac1_en = 0; dac1_out = 0;
        pad_in = 8'hA5;
        tick(4);
        @(negedge clk);
        chk("R1 pad_pu in reset", pad_pu, 8'hF0);
        chk("R1 pad_oe in reset", pad_oe, 8'h00);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data read after reset", bus_rdata, 8'hA1);
        chk("R1 pad_out after reset", pad_out, 8'h00);
        #1;

        // GPIO setup: direction 0F (bit 2 dropped), data 5A.
        bus_write(2'd2, 8'h0F);
        bus_write(2'd0, 8'h5A);
        @(negedge clk);
        chk("R3 pad_oe from direction", pad_oe, 8'h0B);
        chk("R3 pad_out from data", pad_out, 8'h5A);
        chk("R4 mixed direction read", bus_rdata, 8'hAA);
        #1;

        // Writes to the input register and to the spare address change nothing.
        bus_write(2'd1, 8'hFF);
        bus_write(2'd3, 8'hFF);
        bus_addr = 2'd3;
        @(negedge clk);
        chk("R2 spare address reads zero", bus_rdata, 8'h00);
        #1;
        bus_addr = 2'd1;
        @(negedge clk);
        chk("R2 input register after write", bus_rdata, 8'hA1);
        #1;
        bus_addr = 2'd0;
        @(negedge clk);
        chk("R2 data unchanged", bus_rdata, 8'hAA);
        #1;

        // Bit 2 is dropped on direction writes.
        bus_write(2'd2, 8'hFF);
        bus_addr = 2'd2;
        @(negedge clk);
        chk("R6 direction bit 2 reads zero", bus_rdata, 8'hFB);
        chk("R6 pin 2 not driven", pad_oe & 8'h04, 8'h00);
        #1;

        // Synchronizer latency on the input register.
        bus_addr = 2'd1;
        pad_in = 8'h3C;
        tick(1);
        @(negedge clk);
        chk("R5 one edge: old level", bus_rdata, 8'hA1);
        #1;
        tick(0);
        @(negedge clk);
        chk("R5 two edges: new level", bus_rdata, 8'h38);
        #1;

        // Overrides with all pins GPIO outputs at 1.
        bus_write(2'd0, 8'hFF);
        i2c_en = 1; i2c_scl_drive_low = 1; i2c_sda_drive_low = 0;
        uart_rx_en = 1; uart_tx_en = 1; uart_txd = 0;
        dac0_en = 1; dac0_out = 0; dac1_en = 1; dac1_out = 1;
        @(negedge clk);
        chk("R7 open-drain values", pad_out & 8'hC0, 8'h00);
        chk("R7 open-drain enables", pad_oe & 8'hC0, 8'h80);
        chk("R10 pull-up on released data line", pad_pu & 8'hC0, 8'h40);
        chk("R8 receive undriven, transmit driven", pad_oe & 8'h30, 8'h10);
        chk("R8 transmit value", pad_out & 8'h30, 8'h00);
        chk("R9 R11 converter values", pad_out & 8'h03, 8'h02);
        chk("R7 clock line in", {7'd0, i2c_scl_in}, 8'h00);
        #1;
        i2c_en = 0; uart_rx_en = 0; uart_tx_en = 0; dac0_en = 0; dac1_en = 0;
        @(negedge clk);
        chk("R11 release to GPIO out", pad_out, 8'hFB);
        chk("R11 release to GPIO oe", pad_oe, 8'hFB);
        chk("R8 idle receive", {7'd0, uart_rxd}, 8'h01);
        #1;

        // Random phase, checked by the per-clock model comparison.
        for (int i = 0; i < 600; i++) begin
            bus_addr  = 2'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_wdata = 8'($urandom);
            pad_in    = 8'($urandom);
            i2c_en = 1'($urandom); i2c_scl_drive_low = 1'($urandom);
            i2c_sda_drive_low = 1'($urandom);
            uart_rx_en = 1'($urandom); uart_tx_en = 1'($urandom); uart_txd = 1'($urandom);
            dac0_en = 1'($urandom); dac0_out = 1'($urandom);
            dac1_en = 1'($urandom); dac1_out = 1'($urandom);
            if (i == 300) rst_n = 1'b0;
            if (i == 303) rst_n = 1'b1;
            tick(1);
        end
        bus_wr = 1'b0;
        tick(2);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule